// File: doc/BRIEF.md
# PCS Sync-Header Error-Rate Monitor

This block sits in the receive path of a multi-lane 64b/66b PCS, downstream of lane deskew and alignment. On each cycle that carries a block, it reads the block's 2-bit sync header and classifies it as valid or invalid. It counts invalid headers inside a fixed observation window of `WIN_CYCLES` clock cycles. The window length comes from the line rate: 500 µs at the 100G rate and 1.25 ms at the 40G rate, expressed in receive clock cycles.

When 97 invalid headers land in one window, the block raises a high-error-rate flag. The flag stays up until a later window closes with fewer than 97 invalid headers. A receive-accept output combines the flag with lane alignment. The decoder downstream uses this output to decide whether received blocks are passed on to the media-independent interface.

Monitoring runs only while lanes are aligned. Losing alignment restarts the window, clears the count and drops the flag.

Top module: `pcs_hdr_err_mon`

## Requirements
- R1: A sync header of 2'b00 or 2'b11 is invalid. A header of 2'b01 or 2'b10 is valid and never counts.
- R2: A header is counted only on cycles where `blk_vld_i` is high. With the strobe low, the header lines have no effect on the flag.
- R3: `hi_ber_o` goes high at the clock edge that samples the 97th invalid header of a window.
- R4: 96 invalid headers within one window leave `hi_ber_o` low.
- R5: The per-window invalid count saturates at 97 and never wraps. Any number of further invalid headers in that window keeps the flag high.
- R6: While aligned, a window lasts exactly `WIN_CYCLES` cycles, counted from the first aligned cycle. The count restarts at zero in each new window, so invalid headers split across two adjacent windows are never summed.
- R7: At the edge that closes a window, `hi_ber_o` goes low if that window held fewer than 97 invalid headers. It stays high if the window reached 97.
- R8: While `align_ok_i` is low, the flag is cleared at the next edge, and the window timer and invalid count return to zero.
- R9: `rx_accept_o` is high exactly when `align_ok_i` is high and `hi_ber_o` is low. It follows `align_ok_i` within the same cycle.
- R10: A header sampled in the last cycle of a window counts toward the window that is closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| align_ok_i | input | 1 | Lanes deskewed and aligned |
| blk_vld_i | input | 1 | A 66-bit block is present this cycle |
| sync_hdr_i | input | 2 | Sync header of the present block |
| hi_ber_o | output | 1 | High error rate flagged |
| rx_accept_o | output | 1 | Received blocks may be passed on |

## Verification
The bench targets the exact threshold of 96 versus 97 invalid headers. A counter that is off by one would flag one header early or one header late. It feeds 150 invalid headers so that a counter wrapping past the threshold would drop the flag in mid-window. It splits invalid headers across a window boundary and places the 97th header on the last cycle of a window, which catches a counter that does not clear at expiry or that drops the closing cycle's header. It also checks that the flag survives a saturated window's close, clears only at the end of a clean window, and clears at once when alignment is lost.

// File: rtl/ber_pkg.sv
package ber_pkg;
  localparam int unsigned ERR_LIMIT_DEF = 97;
  // 500 us at 390.625 MHz, 1.25 ms at 312.5 MHz (rounded up)
  localparam int unsigned WIN_100G = 195313;
  localparam int unsigned WIN_40G  = 390625;

  function automatic logic hdr_bad(input logic [1:0] hdr);
    return hdr[1] ~^ hdr[0];
  endfunction
endpackage

// File: rtl/ber_hdr_check.sv
module ber_hdr_check (
  input  logic       align_i,
  input  logic       vld_i,
  input  logic [1:0] hdr_i,
  output logic       bad_o
);
  assign bad_o = align_i & vld_i & ber_pkg::hdr_bad(hdr_i);
endmodule

// File: rtl/ber_win_timer.sv
module ber_win_timer #(
  parameter int unsigned WIN_CYCLES = 195313
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic align_i,
  output logic win_end_o
);
  localparam int unsigned TW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  assign win_end_o = align_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!align_i)  cnt_q <= '0;
    else if (win_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  p_timer_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_timer_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !align_i |=> cnt_q == '0);
endmodule

// File: rtl/ber_err_count.sv
module ber_err_count #(
  parameter int unsigned ERR_LIMIT = 97
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic align_i,
  input  logic bad_i,
  input  logic win_end_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(ERR_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(ERR_LIMIT);

  logic [CW-1:0] err_q, err_nxt;
  logic          sat;

  assign sat     = (err_q == LIM);
  assign err_nxt = err_q + CW'(bad_i && !sat);
  assign hit_o   = (err_nxt == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= '0;
    else if (!align_i)  err_q <= '0;
    else if (win_end_i) err_q <= '0;
    else                err_q <= err_nxt;
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q <= LIM);
  p_win_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_i |=> err_q == '0);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_i && !bad_i && !win_end_i) |=> $stable(err_q));
endmodule

// File: rtl/pcs_hdr_err_mon.sv
module pcs_hdr_err_mon #(
  parameter int unsigned WIN_CYCLES = ber_pkg::WIN_100G,
  parameter int unsigned ERR_LIMIT  = ber_pkg::ERR_LIMIT_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       align_ok_i,
  input  logic       blk_vld_i,
  input  logic [1:0] sync_hdr_i,
  output logic       hi_ber_o,
  output logic       rx_accept_o
);
  logic bad, win_end, hit, hi_q;

  ber_hdr_check u_chk (
    .align_i (align_ok_i),
    .vld_i   (blk_vld_i),
    .hdr_i   (sync_hdr_i),
    .bad_o   (bad)
  );

  ber_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .align_i   (align_ok_i),
    .win_end_o (win_end)
  );

  ber_err_count #(.ERR_LIMIT(ERR_LIMIT)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .align_i   (align_ok_i),
    .bad_i     (bad),
    .win_end_i (win_end),
    .hit_o     (hit)
  );

  // threshold hit wins over window close; the closing cycle's header is included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_q <= 1'b0;
    else if (!align_ok_i) hi_q <= 1'b0;
    else if (hit)        hi_q <= 1'b1;
    else if (win_end)    hi_q <= 1'b0;
  end

  assign hi_ber_o    = hi_q;
  assign rx_accept_o = align_ok_i & ~hi_q;

  p_set_on_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_ok_i && hit) |=> hi_q);
  p_clear_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_ok_i && win_end && !hit) |=> !hi_q);
  p_drop_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !align_ok_i |=> !hi_q);
  p_set_needs_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_q) |-> $past(hit));
endmodule

// File: tb/pcs_hdr_err_mon_test.sv
module pcs_hdr_err_mon_test;
  localparam int unsigned WIN = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic align = 1'b0, vld = 1'b0;
  logic [1:0] hdr = 2'b01;
  logic hi, acc;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pcs_hdr_err_mon #(.WIN_CYCLES(WIN), .ERR_LIMIT(97)) uut (
    .clk_i(clk), .rst_ni(rst_n), .align_ok_i(align), .blk_vld_i(vld),
    .sync_hdr_i(hdr), .hi_ber_o(hi), .rx_accept_o(acc)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [1:0]  h;
    logic        v;
    logic [8:0]  n;
    logic        exp_hi;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{"R1 ", 2'b00, 1'b1, 9'd97,  1'b1},
    '{"R1 ", 2'b11, 1'b1, 9'd97,  1'b1},
    '{"R1 ", 2'b01, 1'b1, 9'd97,  1'b0},
    '{"R1 ", 2'b10, 1'b1, 9'd97,  1'b0},
    '{"R4 ", 2'b00, 1'b1, 9'd96,  1'b0},
    '{"R2 ", 2'b11, 1'b0, 9'd97,  1'b0},
    '{"R5 ", 2'b00, 1'b1, 9'd150, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, run one edge, return at next negedge
  task automatic step(input logic a, input logic v, input logic [1:0] h);
    align = a; vld = v; hdr = h;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic v, input logic [1:0] h);
    for (int i = 0; i < n; i++) step(1'b1, v, h);
  endtask

  task automatic fresh();
    step(1'b0, 1'b0, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", hi, 1'b0);
    check("R9 reset", acc, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    align = 1'b1; #1;
    check("R9 aligned", acc, 1'b1);

    // table walk
    foreach (VEC[k]) begin
      fresh();
      run(int'(VEC[k].n), VEC[k].v, VEC[k].h);
      check(string'(VEC[k].tag), hi, VEC[k].exp_hi);
      check("R9 table", acc, ~VEC[k].exp_hi);
    end

    // R3/R7: saturated window holds flag, clean window clears it
    fresh();
    run(96, 1'b1, 2'b00);
    check("R3 96th", hi, 1'b0);
    run(1, 1'b1, 2'b00);
    check("R3 97th", hi, 1'b1);
    run(302, 1'b1, 2'b01);
    check("R7 before end", hi, 1'b1);
    run(1, 1'b1, 2'b01);
    check("R7 held at end", hi, 1'b1);
    run(399, 1'b1, 2'b10);
    check("R7 clean window open", hi, 1'b1);
    run(1, 1'b1, 2'b10);
    check("R7 clean window end", hi, 1'b0);
    check("R9 after clear", acc, 1'b1);

    // R6: errors split across windows do not sum
    fresh();
    run(340, 1'b1, 2'b01);
    run(60, 1'b1, 2'b11);
    run(60, 1'b1, 2'b00);
    check("R6 split", hi, 1'b0);

    // R10: 97th header on last window cycle
    fresh();
    run(303, 1'b1, 2'b01);
    run(97, 1'b1, 2'b11);
    check("R10 last cycle", hi, 1'b1);
    run(1, 1'b1, 2'b01);
    check("R10 next window", hi, 1'b1);

    // R8: alignment loss clears flag
    align = 1'b0; #1;
    check("R9 align low", acc, 1'b0);
    step(1'b0, 1'b0, 2'b01);
    check("R8 drop", hi, 1'b0);
    align = 1'b1; #1;
    check("R9 realign", acc, 1'b1);
    // R8: timer restarted; 97 errors near old window end still flag
    run(97, 1'b1, 2'b00);
    check("R8 restart", hi, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule